// File: doc/BRIEF.md
# Masked Sticky Interrupt Control Register

This block is a single 32-bit control register that sits in a graphics engine's register space and collects two hardware conditions: "engine idle" and "command buffer empty". Each condition has a mask bit and a sticky detect bit. A condition is latched only while its mask bit is clear. A latched bit stays set until software clears it by writing a one to it. The block drives a registered interrupt line and a pending flag, and both are high whenever any detect bit is set.

Software reaches the register through a simple synchronous bus with a write strobe, a read strobe and four byte-enable lanes. The bus has no address decode because the register sits at a single offset. Reset leaves both sources masked. Bits with no function return fixed values. A clean way to acknowledge every pending interrupt at once is to read the register and write the same value back.

Top module: `irq_ctl_reg`

## Requirements
- R1: After synchronous active-high reset, a read returns 0x0000FFFF and both `irq` and `pend_flag` are low.
- R2: A write with `reg_be[0]` high loads mask bits 1:0 from `reg_wdata[1:0]`. Bit 1 masks engine idle and bit 0 masks command buffer empty. With `reg_be[0]` low the mask bits are unchanged.
- R3: A set mask bit (1) blocks its source, and an event pulse on that source latches nothing.
- R4: An event pulse with its mask bit at 0 sets its detect bit at that clock edge. Engine idle sets bit 17 and command buffer empty sets bit 16.
- R5: Detect bits are sticky. A write with `reg_be[2]` high clears every detect bit whose `reg_wdata` bit is 1, and leaves every detect bit whose `reg_wdata` bit is 0 unchanged.
- R6: Detect bits can be cleared only through byte lane 2. A write with `reg_be[2]` low leaves them unchanged.
- R7: When an event and a clear hit the same detect bit at the same edge, the bit ends up set.
- R8: Setting a mask bit does not clear a detect bit that is already latched.
- R9: Bits 31:18 always read 0 and bits 15:2 always read 1. Writes to those bits have no effect.
- R10: `irq` and `pend_flag` equal the OR of the detect bits, and they change at the same edge as the detect bits.
- R11: Writing back, with all lanes enabled, the value just read clears every pending detect bit and leaves the mask unchanged.
- R12: A read strobe captures the register view, as it stood before that edge, into `reg_rdata`. The data is valid after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_be | input | 4 | Byte-lane enables for writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| evt_cmd_empty | input | 1 | Command buffer empty pulse |
| evt_idle | input | 1 | Engine idle pulse |
| irq | output | 1 | Registered interrupt line |
| pend_flag | output | 1 | Any detect bit set |

## Verification
A hardware event and a software write-one-to-clear can strike the same detect bit at the same clock edge. The bench provokes this collision by sweeping every mask value, every combination of event pulses and every clear pattern within a single cycle. It then reads the register back and compares it, together with `irq` and `pend_flag`, against a next-state value computed arithmetically from the requirements. In that model a set always beats a clear.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int REG_W   = 32;
  localparam int NUM_SRC = 2;
  localparam int DET_LSB = 16;
  localparam int BE_W    = REG_W / 8;
  localparam int SRC_CMD_EMPTY = 0;
  localparam int SRC_IDLE      = 1;
endpackage

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int NUM_SRC = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lane_wr,
  input  logic [NUM_SRC-1:0] wbits,
  output logic [NUM_SRC-1:0] mask
);
  always_ff @(posedge clk) begin
    if (rst)          mask <= '1;
    else if (lane_wr) mask <= wbits;
  end

  // R2: mask is only altered by a lane-0 write
  assert_mask_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !lane_wr |=> $stable(mask));
  assert_mask_load_R2: assert property (@(posedge clk) disable iff (rst)
    lane_wr |=> (mask == $past(wbits)));
endmodule

// File: rtl/irq_detect_bank.sv
module irq_detect_bank #(
  parameter int NUM_SRC = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] evt,
  input  logic [NUM_SRC-1:0] mask,
  input  logic [NUM_SRC-1:0] clr,
  output logic [NUM_SRC-1:0] det,
  output logic [NUM_SRC-1:0] det_nxt
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign det_nxt[g] = (det[g] & ~clr[g]) | (evt[g] & ~mask[g]);

    always_ff @(posedge clk) begin
      if (rst) det[g] <= 1'b0;
      else     det[g] <= det_nxt[g];
    end

    // R4 and R7: an unmasked event latches, even against a clear
    assert_latch_R4: assert property (@(posedge clk) disable iff (rst)
      (evt[g] && !mask[g]) |=> det[g]);
    // R5: sticky without a clear
    assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
      (det[g] && !clr[g]) |=> det[g]);
    // R3: masked or absent event never sets a clear bit
    assert_blocked_R3: assert property (@(posedge clk) disable iff (rst)
      (!det[g] && (mask[g] || !evt[g])) |=> !det[g]);
  end
endmodule

// File: rtl/irq_read_view.sv
module irq_read_view #(
  parameter int REG_W   = 32,
  parameter int NUM_SRC = 2,
  parameter int DET_LSB = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd,
  input  logic [NUM_SRC-1:0] det,
  input  logic [NUM_SRC-1:0] mask,
  output logic [REG_W-1:0]   rdata
);
  localparam int DET_MSB = DET_LSB + NUM_SRC - 1;
  localparam logic [REG_W-1:0] RST_VIEW = (REG_W'(1) << DET_LSB) - REG_W'(1);

  logic [REG_W-1:0] view;

  always_comb begin
    for (int b = 0; b < REG_W; b++) begin
      if (b < NUM_SRC)                       view[b] = mask[b];
      else if (b < DET_LSB)                  view[b] = 1'b1;
      else if (b <= DET_MSB)                 view[b] = det[b - DET_LSB];
      else                                   view[b] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= RST_VIEW;
    else if (rd) rdata <= view;
  end

  // R9: fixed fields in the returned data
  assert_resv_hi_R9: assert property (@(posedge clk) disable iff (rst)
    rdata[REG_W-1:DET_MSB+1] == '0);
  assert_resv_lo_R9: assert property (@(posedge clk) disable iff (rst)
    rdata[DET_LSB-1:NUM_SRC] == '1);
  // R12: data only moves on a read strobe
  assert_rd_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rdata));
endmodule

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg
  import irq_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [BE_W-1:0]   reg_be,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              evt_cmd_empty,
  input  logic              evt_idle,
  output logic              irq,
  output logic              pend_flag
);
  localparam int DET_LANE  = DET_LSB / 8;
  localparam int MASK_LANE = 0;

  logic [NUM_SRC-1:0] evt, mask, clr, det, det_nxt;
  logic               mask_wr;

  always_comb begin
    evt = '0;
    evt[SRC_CMD_EMPTY] = evt_cmd_empty;
    evt[SRC_IDLE]      = evt_idle;
  end

  assign mask_wr = reg_wr & reg_be[MASK_LANE];
  assign clr     = {NUM_SRC{reg_wr & reg_be[DET_LANE]}}
                   & reg_wdata[DET_LSB +: NUM_SRC];

  irq_mask_bank #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk(clk), .rst(rst), .lane_wr(mask_wr),
    .wbits(reg_wdata[NUM_SRC-1:0]), .mask(mask)
  );

  irq_detect_bank #(.NUM_SRC(NUM_SRC)) u_det (
    .clk(clk), .rst(rst), .evt(evt), .mask(mask), .clr(clr),
    .det(det), .det_nxt(det_nxt)
  );

  irq_read_view #(.REG_W(REG_W), .NUM_SRC(NUM_SRC), .DET_LSB(DET_LSB)) u_view (
    .clk(clk), .rst(rst), .rd(reg_rd), .det(det), .mask(mask),
    .rdata(reg_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |det_nxt;
  end

  assign pend_flag = |det;

  // R10: an unmasked event raises the line at that edge
  assert_irq_rise_R10: assert property (@(posedge clk) disable iff (rst)
    ((evt & ~mask) != '0) |=> irq);
  // R6: no lane-2 write, no detect bit falls
  assert_clr_lane_R6: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_be[DET_LANE]) |=> ((det & $past(det)) == $past(det)));
  // R8: mask write alone never drops a latched bit
  assert_mask_keep_R8: assert property (@(posedge clk) disable iff (rst)
    (mask_wr && !reg_be[DET_LANE]) |=> ((det & $past(det)) == $past(det)));
endmodule

// File: tb/irq_ctl_reg_bench.sv
module irq_ctl_reg_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr, reg_rd;
  logic [3:0]  reg_be;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        evt_cmd_empty, evt_idle;
  logic        irq, pend_flag;

  int total = 0;
  int bad   = 0;
  logic [1:0] m_mask = 2'b11;
  logic [1:0] m_det  = 2'b00;
  logic [31:0] m_rd  = 32'h0000FFFF;

  always #5 clk = ~clk;

  irq_ctl_reg u_irq_ctl_reg (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_cmd_empty(evt_cmd_empty), .evt_idle(evt_idle),
    .irq(irq), .pend_flag(pend_flag)
  );

  function automatic logic [31:0] view(input logic [1:0] d, input logic [1:0] m);
    return {14'h0, d, 14'h3FFF, m};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // one bus/event cycle; model updated from the requirements
  task automatic cyc(input logic wr, input logic [3:0] be, input logic [31:0] wd,
                     input logic rd, input logic [1:0] ev);
    logic [1:0] clr;
    reg_wr = wr; reg_be = be; reg_wdata = wd; reg_rd = rd;
    evt_cmd_empty = ev[0]; evt_idle = ev[1];
    @(posedge clk);
    clr = (wr && be[2]) ? wd[17:16] : 2'b00;
    if (rd) m_rd = view(m_det, m_mask);
    m_det = (m_det & ~clr) | (ev & ~m_mask);
    if (wr && be[0]) m_mask = wd[1:0];
    @(negedge clk);
    reg_wr = 0; reg_rd = 0; reg_be = 0; reg_wdata = 0;
    evt_cmd_empty = 0; evt_idle = 0;
    chk("R10 irq", {31'h0, irq}, {31'h0, |m_det});
    chk("R10 pend", {31'h0, pend_flag}, {31'h0, |m_det});
  endtask

  task automatic rd_chk(input string req);
    cyc(0, 4'h0, 0, 1, 2'b00);
    chk(req, reg_rdata, m_rd);
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] snap;
    rst = 1; reg_wr = 0; reg_rd = 0; reg_be = 0; reg_wdata = 0;
    evt_cmd_empty = 0; evt_idle = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 rdata", reg_rdata, 32'h0000FFFF);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    rd_chk("R1 read");
    // R3 masked events ignored
    cyc(0, 4'h0, 0, 0, 2'b11);
    rd_chk("R3 masked");
    // R2 mask write on lane 0 only
    cyc(1, 4'b1110, 32'h0, 0, 2'b00);
    rd_chk("R2 other lanes");
    cyc(1, 4'b0001, 32'h0, 0, 2'b00);
    rd_chk("R2 lane0");
    // R4 each source to its bit
    cyc(0, 4'h0, 0, 0, 2'b10);
    rd_chk("R4 idle bit17");
    cyc(0, 4'h0, 0, 0, 2'b01);
    rd_chk("R4 empty bit16");
    chk("R4 value", reg_rdata, 32'h0003FFFC);
    // R8 masking keeps latched bits
    cyc(1, 4'b0001, 32'h3, 0, 2'b00);
    rd_chk("R8 mask keep");
    // R6 clear through other lanes ignored
    cyc(1, 4'b1011, 32'hFFFF_FFFC, 0, 2'b00);
    rd_chk("R6 no lane2");
    // R9 reserved bits unaffected
    cyc(1, 4'b1111, 32'hFFFC_0003, 0, 2'b00);
    rd_chk("R9 reserved");
    // R5 write 0 no effect, write 1 clears one bit
    cyc(1, 4'b0100, 32'h0000_0000, 0, 2'b00);
    rd_chk("R5 zero");
    cyc(1, 4'b0100, 32'h0002_0000, 0, 2'b00);
    rd_chk("R5 clear17");
    chk("R5 value", reg_rdata, 32'h0001FFFF);
    // R11 read then write back
    cyc(1, 4'b0001, 32'h0, 0, 2'b00);
    cyc(0, 4'h0, 0, 0, 2'b11);
    rd_chk("R11 read");
    snap = reg_rdata;
    cyc(1, 4'hF, snap, 0, 2'b00);
    rd_chk("R11 writeback");
    chk("R11 value", reg_rdata, 32'h0000FFFC);
    // R7 sweep: mask x event x clear in the same cycle
    for (int m = 0; m < 4; m++)
      for (int e = 0; e < 4; e++)
        for (int c = 0; c < 4; c++)
          for (int p = 0; p < 4; p++) begin
            cyc(1, 4'b0101, 32'h0003_0000 | 32'(m), 0, 2'b00);
            cyc(0, 4'h0, 0, 0, 2'(p));
            cyc(1, 4'b0100, 32'(c) << 16, 0, 2'(e));
            rd_chk("R7 R12 sweep");
          end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule